// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Unit

This block moves a register operand by exactly one bit position, or inverts it, at a selectable width of 8, 16 or 32 bits. An operation code selects a logical or arithmetic shift, a plain rotate, a rotate that passes through the carry flag, or bitwise NOT. The block returns the new operand value together with fresh negative (N), zero (Z), overflow (V) and carry (C) condition flags. The caller supplies the current carry flag, which the carry-through rotates and NOT need.

One shared datapath holds a lane for each width. The width select picks the lane, so the position of the most significant bit (used for the outgoing carry, the sign of an arithmetic shift and the N flag) follows the selected width. Results and flags are captured in an output register one clock after a valid request, and a one-cycle strobe marks each result. Fetching the operand, writing the result back to a register file, and shift counts above one are left to the surrounding logic.

Top module: `shrot_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `out_data` and all four flag outputs are 0.
- R2: A request with `in_valid` high at a rising edge produces its result and flags on the outputs after that edge, with `out_valid` high for that one cycle. `out_valid` is low after any edge where `in_valid` was low, and the result and flag outputs then hold their previous values. Back-to-back requests produce back-to-back results.
- R3: Shift codes: 1 = logical left (0 enters bit 0), 2 = logical right (0 enters the MSB), 3 = arithmetic left (same result as code 1), 4 = arithmetic right (the original MSB is kept in the MSB).
- R4: Rotate codes: 5 = rotate left (the old MSB enters bit 0), 6 = rotate right (the old bit 0 enters the MSB).
- R5: Carry-through rotate codes: 7 = rotate left with the incoming `in_carry` entering bit 0, and 8 = rotate right with `in_carry` entering the MSB.
- R6: For codes 1, 3, 5 and 7 the new C is the operand's MSB at the selected width. For codes 2, 4, 6 and 8 the new C is the operand's bit 0.
- R7: Code 0 = NOT: the result is the bitwise inverse of the operand at the selected width, and C equals `in_carry`.
- R8: N is the result's MSB at the selected width, Z is 1 exactly when the result at that width is zero, and V is 0 for every operation.
- R9: Width select `in_size`: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Operand bits above the selected width have no effect, and result bits above it are 0.
- R10: Codes 9 to 15 are not operations: the result is the operand at the selected width, unchanged, and C equals `in_carry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe: operand, code and width are taken this cycle |
| in_op | input | 4 | Operation code (see R3, R4, R5, R7, R10) |
| in_size | input | 2 | Width select (see R9) |
| in_data | input | 32 | Operand |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | High for one cycle when a new result is present |
| out_data | output | 32 | Result, zero above the selected width |
| out_n | output | 1 | Negative flag of the result |
| out_z | output | 1 | Zero flag of the result |
| out_v | output | 1 | Overflow flag, always cleared |
| out_c | output | 1 | Carry flag after the operation |

## Verification
The bench drives operands whose bit 0 and MSB differ at each width, with junk above the selected width, so a design that took the MSB or carry from a fixed bit 31, or let high garbage leak into the result or the Z flag, would report wrong data or flags for 8- and 16-bit requests. The carry-through rotates run with both values of the incoming carry, which catches a design that loads the carry into the wrong end or that treats them as plain rotates. Arithmetic right shifts of negative and positive values catch a sign bit that is dropped or taken from the wrong position, and NOT and the unused codes are given an incoming carry that a wrong design would overwrite. Idle cycles and back-to-back requests check that the strobe lasts exactly one cycle and that outputs hold between results.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int OP_W   = 4;
    localparam int SIZE_W = 2;
    localparam int BYTE_W = 8;
    localparam int NUM_LANES = 3;

    typedef enum logic [OP_W-1:0] {
        OP_INV    = 4'd0,
        OP_LSL    = 4'd1,
        OP_LSR    = 4'd2,
        OP_ASL    = 4'd3,
        OP_ASR    = 4'd4,
        OP_ROL    = 4'd5,
        OP_ROR    = 4'd6,
        OP_RCL    = 4'd7,
        OP_RCR    = 4'd8
    } shrot_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } shrot_flags_t;

    // Lane index for a width select: 0 -> 8 bits, 1 -> 16 bits, 2/3 -> 32 bits.
    function automatic logic [1:0] size_to_lane(input logic [SIZE_W-1:0] sz);
        logic [1:0] idx;
        case (sz)
            2'd0:    idx = 2'd0;
            2'd1:    idx = 2'd1;
            default: idx = 2'd2;
        endcase
        return idx;
    endfunction

    // True when the code moves bits toward the MSB.
    function automatic logic is_leftward(input logic [OP_W-1:0] op);
        return (op == OP_LSL) || (op == OP_ASL) || (op == OP_ROL) || (op == OP_RCL);
    endfunction

    // True when the code moves bits toward bit 0.
    function automatic logic is_rightward(input logic [OP_W-1:0] op);
        return (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR) || (op == OP_RCR);
    endfunction

endpackage

// File: rtl/shrot_lane.sv
// One fixed-width lane: computes the shifted/rotated/inverted value and the carry.
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);
    logic top_bit;
    logic low_bit;

    assign top_bit = a[W-1];
    assign low_bit = a[0];

    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            OP_INV: begin
                res  = ~a;
                cout = cin;
            end
            OP_LSL, OP_ASL: begin
                res  = {a[W-2:0], 1'b0};
                cout = top_bit;
            end
            OP_LSR: begin
                res  = {1'b0, a[W-1:1]};
                cout = low_bit;
            end
            OP_ASR: begin
                res  = {top_bit, a[W-1:1]};
                cout = low_bit;
            end
            OP_ROL: begin
                res  = {a[W-2:0], top_bit};
                cout = top_bit;
            end
            OP_ROR: begin
                res  = {low_bit, a[W-1:1]};
                cout = low_bit;
            end
            OP_RCL: begin
                res  = {a[W-2:0], cin};
                cout = top_bit;
            end
            OP_RCR: begin
                res  = {cin, a[W-1:1]};
                cout = low_bit;
            end
            default: begin
                res  = a;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/shrot_flags.sv
// Derives N and Z from a zero-extended result, with the sign position set by the lane.
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic [1:0]        lane,
    output logic              n,
    output logic              z
);
    logic [NUM_LANES-1:0] sign_per_lane;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_sign
        localparam int MSB_POS = (BYTE_W << g) - 1;
        assign sign_per_lane[g] = res[MSB_POS];
    end

    always_comb begin
        n = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (lane == i[1:0]) n = sign_per_lane[i];
        end
    end

    assign z = (res == '0);
endmodule

// File: rtl/shrot_engine.sv
// Combinational engine: one lane per width, selected by the width code.
module shrot_engine
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] data,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output shrot_flags_t      flags
);
    logic [DATA_W-1:0]    lane_res [NUM_LANES];
    logic [NUM_LANES-1:0] lane_c;
    logic [1:0]           lane_sel;
    logic                 n_flag;
    logic                 z_flag;
    logic                 c_flag;

    assign lane_sel = size_to_lane(size);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = BYTE_W << g;
        logic [LW-1:0] part;
        shrot_lane #(.W(LW)) u_lane (
            .op   (op),
            .a    (data[LW-1:0]),
            .cin  (cin),
            .res  (part),
            .cout (lane_c[g])
        );
        assign lane_res[g] = DATA_W'(part);
    end

    always_comb begin
        res    = lane_res[NUM_LANES-1];
        c_flag = lane_c[NUM_LANES-1];
        for (int i = 0; i < NUM_LANES; i++) begin
            if (lane_sel == i[1:0]) begin
                res    = lane_res[i];
                c_flag = lane_c[i];
            end
        end
    end

    shrot_flags #(.DATA_W(DATA_W)) u_flags (
        .res  (res),
        .lane (lane_sel),
        .n    (n_flag),
        .z    (z_flag)
    );

    always_comb begin
        flags.n = n_flag;
        flags.z = z_flag;
        flags.v = 1'b0;
        flags.c = c_flag;
    end
endmodule

// File: rtl/shrot_unit.sv
// Top: combinational engine followed by one output register stage.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [1:0]        in_size,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_n,
    output logic              out_z,
    output logic              out_v,
    output logic              out_c
);
    logic [DATA_W-1:0] eng_res;
    shrot_flags_t      eng_flags;
    shrot_flags_t      flags_q;

    shrot_engine #(.DATA_W(DATA_W)) u_engine (
        .op    (in_op),
        .size  (in_size),
        .data  (in_data),
        .cin   (in_carry),
        .res   (eng_res),
        .flags (eng_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= eng_res;
                flags_q  <= eng_flags;
            end
        end
    end

    assign out_n = flags_q.n;
    assign out_z = flags_q.z;
    assign out_v = flags_q.v;
    assign out_c = flags_q.c;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        in_op,
    input logic [1:0]        in_size,
    input logic [DATA_W-1:0] in_data,
    input logic              in_carry,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_n,
    input logic              out_z,
    input logic              out_v,
    input logic              out_c
);
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_c) && $stable(out_z))); // R2
    AST_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_v); // R8
    AST_NOT_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 4'd0) |=> (out_c == $past(in_carry))); // R7
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd0) |=> (out_data[DATA_W-1:8] == '0)); // R9
    AST_BYTE_ZFLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd0) |=> (out_z == (out_data[7:0] == 8'd0))); // R8
    AST_LEFT_CARRY_WORD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd1 && in_op == 4'd1) |=> (out_c == $past(in_data[15]))); // R6
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_size   (in_size),
    .in_data   (in_data),
    .in_carry  (in_carry),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_n     (out_n),
    .out_z     (out_z),
    .out_v     (out_v),
    .out_c     (out_c)
);

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [3:0]    in_op = '0;
    logic [1:0]    in_size = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_carry = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_n, out_z, out_v, out_c;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    shrot_unit #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_data(in_data), .in_carry(in_carry),
        .out_valid(out_valid), .out_data(out_data),
        .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c)
    );

    // Expected {n,z,v,c,result} from the requirement text.
    function automatic logic [35:0] expect_of(input logic [3:0] op, input logic [1:0] sz,
                                              input logic [31:0] d, input logic ci);
        int w;
        logic [63:0] m, a, r;
        logic hi, lo, c;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m  = (64'd1 << w) - 64'd1;
        a  = {32'd0, d} & m;
        hi = a[w-1];
        lo = a[0];
        c  = ci;
        r  = a;
        case (op)
            4'd0: r = ~a;
            4'd1, 4'd3: begin r = a << 1; c = hi; end
            4'd2: begin r = a >> 1; c = lo; end
            4'd4: begin r = (a >> 1) | ({63'd0, hi} << (w-1)); c = lo; end
            4'd5: begin r = (a << 1) | {63'd0, hi}; c = hi; end
            4'd6: begin r = (a >> 1) | ({63'd0, lo} << (w-1)); c = lo; end
            4'd7: begin r = (a << 1) | {63'd0, ci}; c = hi; end
            4'd8: begin r = (a >> 1) | ({63'd0, ci} << (w-1)); c = lo; end
            default: r = a;
        endcase
        r = r & m;
        return {r[w-1], (r == 64'd0), 1'b0, c, r[31:0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request at a falling edge, check it one rising edge later.
    task automatic run_op(input string req, input logic [3:0] op, input logic [1:0] sz,
                          input logic [31:0] d, input logic ci);
        logic [35:0] e;
        e = expect_of(op, sz, d, ci);
        in_valid = 1'b1; in_op = op; in_size = sz; in_data = d; in_carry = ci;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~d;
        in_carry = ~ci;
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check({req, " data"},  {32'd0, out_data}, {32'd0, e[31:0]});
        check({req, " flags"}, {60'd0, out_n, out_z, out_v, out_c}, {60'd0, e[35:32]});
    endtask

    task automatic t_reset;
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 data/flags", {28'd0, out_data, out_n, out_z, out_v, out_c}, 64'd0);
    endtask

    task automatic t_shifts;
        run_op("R3 lsl b", 4'd1, 2'd0, 32'hFFFF_FF81, 1'b0);
        run_op("R3 lsr w", 4'd2, 2'd1, 32'h1234_8001, 1'b1);
        run_op("R3 asl l", 4'd3, 2'd2, 32'h4000_0001, 1'b0);
        run_op("R3 asr b neg", 4'd4, 2'd0, 32'h0000_0085, 1'b0);
        run_op("R3 asr w pos", 4'd4, 2'd1, 32'hFFFF_7FFE, 1'b1);
        run_op("R3 asr l neg", 4'd4, 2'd3, 32'h8000_0000, 1'b0);
    endtask

    task automatic t_rotates;
        run_op("R4 rol b", 4'd5, 2'd0, 32'h0000_AA80, 1'b0);
        run_op("R4 ror w", 4'd6, 2'd1, 32'h0000_0001, 1'b0);
        run_op("R4 rol l", 4'd5, 2'd2, 32'h8000_0001, 1'b0);
        run_op("R4 ror l", 4'd6, 2'd2, 32'h0000_0002, 1'b1);
    endtask

    task automatic t_rotx;
        run_op("R5 rcl b c1", 4'd7, 2'd0, 32'h0000_0040, 1'b1);
        run_op("R5 rcl w c0", 4'd7, 2'd1, 32'h0000_8000, 1'b0);
        run_op("R5 rcr b c1", 4'd8, 2'd0, 32'hFF00_0002, 1'b1);
        run_op("R5 rcr l c0", 4'd8, 2'd2, 32'h0000_0001, 1'b0);
    endtask

    task automatic t_carry;
        run_op("R6 left msb w", 4'd1, 2'd1, 32'h0001_8000, 1'b0);
        run_op("R6 right lsb b", 4'd2, 2'd0, 32'h0000_0100, 1'b1);
    endtask

    task automatic t_not;
        run_op("R7 not b", 4'd0, 2'd0, 32'h1234_56FF, 1'b1);
        run_op("R7 not l", 4'd0, 2'd2, 32'h0F0F_0F0F, 1'b0);
    endtask

    task automatic t_flags;
        run_op("R8 zero l", 4'd1, 2'd2, 32'h8000_0000, 1'b0);
        run_op("R8 neg w", 4'd2, 2'd1, 32'h0000_0000, 1'b0);
        run_op("R8 sign b", 4'd5, 2'd0, 32'h0000_0040, 1'b0);
    endtask

    task automatic t_width;
        run_op("R9 junk above b", 4'd2, 2'd0, 32'hABCD_EF00, 1'b0);
        run_op("R9 size3 is 32", 4'd1, 2'd3, 32'hC000_0000, 1'b0);
    endtask

    task automatic t_undef;
        run_op("R10 code9", 4'd9, 2'd1, 32'hDEAD_BEEF, 1'b1);
        run_op("R10 code15", 4'd15, 2'd0, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_timing;
        logic [35:0] e1, e2;
        logic [31:0] held;
        e1 = expect_of(4'd1, 2'd0, 32'h01, 1'b0);
        e2 = expect_of(4'd2, 2'd0, 32'h80, 1'b0);
        in_valid = 1'b1; in_op = 4'd1; in_size = 2'd0; in_data = 32'h01; in_carry = 1'b0;
        @(negedge clk);
        check("R2 b2b first", {31'd0, out_valid, out_data}, {31'd0, 1'b1, e1[31:0]});
        in_op = 4'd2; in_data = 32'h80;
        @(negedge clk);
        check("R2 b2b second", {31'd0, out_valid, out_data}, {31'd0, 1'b1, e2[31:0]});
        in_valid = 1'b0; in_op = 4'd0; in_data = 32'h55; in_carry = 1'b1;
        held = out_data;
        @(negedge clk);
        check("R2 strobe drops", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check("R2 outputs hold", {31'd0, out_c, out_data}, {31'd0, e2[32], held});
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_shifts();
        t_rotates();
        t_rotx();
        t_carry();
        t_not();
        t_flags();
        t_width();
        t_undef();
        t_timing();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule